// File: doc/BRIEF.md
# USB path switch enable controller

This block decides when two analog data-mux switch paths and a protected power path may be switched on. It follows the supply through three phases: absent, detecting and ready. The supply phase comes from a flag that is high while VBUS is above its undervoltage threshold. The detection phase ends on a done strobe from the charger-detection logic. The block also holds a small register state, which a host writes through a select, data and write-enable interface.

The mux switches stay off until detection has completed. After that, the first mux defaults on and the second defaults off. Each then follows its register bit, and the first mux always has priority over the second. The power path starts in a 100 mA limited mode for dead-battery support. It leaves that mode only when the ready phase is reached and the overvoltage-switch bit (config bit 0) and the VBUS-override bit (config bit 2) are both set. When VBUS falls below the threshold, all register state and the phase return to their defaults.

Top module: `path_sw_ctrl`

## Requirements
- R1: While vbus_ok_i is low, and one clock after it falls, the outputs are mux_a_en_o=0, mux_b_en_o=0, ilim_o=1 and full_path_o=0.
- R2: From the clock after vbus_ok_i rises until the clock that samples det_done_i high, both mux enables are 0 and full_path_o is 0, whatever the registers hold.
- R3: With reset register values, the clock that samples det_done_i high in the detecting phase makes mux_a_en_o=1.
- R4: The mux register (reg_sel_i=0) resets to 8'h01: bit 0 requests mux A and bit 1 requests mux B. Once ready, mux_b_en_o equals bit 1 unless bit 0 is also set.
- R5: mux_a_en_o and mux_b_en_o are never both 1. When both bits are set, only mux A is enabled.
- R6: The config register (reg_sel_i=1) resets to 0. In the ready phase, full_path_o=1 and ilim_o=0 exactly when config bits 0 and 2 are both 1. Otherwise ilim_o=1 and full_path_o=0.
- R7: After VBUS drops and returns, and detection completes again, both registers hold their reset values.
- R8: Register writes sampled while vbus_ok_i is low have no effect.
- R9: det_done_i sampled while vbus_ok_i is low, or in the ready phase, does not change the phase.
- R10: The detecting phase is left only on a sampled det_done_i or on loss of VBUS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vbus_ok_i | input | 1 | VBUS above undervoltage threshold; low clears all state synchronously |
| det_done_i | input | 1 | Charger detection complete strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 1 | 0 selects the mux register, 1 selects the config register |
| reg_wdata_i | input | 8 | Register write data |
| mux_a_en_o | output | 1 | Gated enable for mux path A |
| mux_b_en_o | output | 1 | Gated enable for mux path B |
| ilim_o | output | 1 | 100 mA current limit active |
| full_path_o | output | 1 | Unlimited power path enabled |

## Verification
The assertions assume that rst_ni is applied once at start-up and that every later return to defaults comes through vbus_ok_i alone. They also assume that all inputs change away from the rising clock edge. The bench drives every input on the falling edge and releases rst_ni only while vbus_ok_i is low. It sweeps all mux-register and config-bit combinations only after a full detection cycle, and it raises det_done_i both inside and outside the detecting phase.

// File: rtl/path_ctrl_pkg.sv
package path_ctrl_pkg;
  localparam int unsigned REG_W = 8;

  typedef enum logic [1:0] {
    PH_OFF    = 2'd0,
    PH_DETECT = 2'd1,
    PH_READY  = 2'd2
  } phase_e;

  localparam logic SEL_MUX = 1'b0;
  localparam logic SEL_CFG = 1'b1;

  localparam int unsigned MUX_A_BIT = 0;
  localparam int unsigned MUX_B_BIT = 1;
  localparam int unsigned OVP_BIT   = 0;
  localparam int unsigned OVR_BIT   = 2;

  localparam logic [REG_W-1:0] MUX_RST = 8'h01;
  localparam logic [REG_W-1:0] CFG_RST = 8'h00;
endpackage

// File: rtl/pwr_phase_fsm.sv
module pwr_phase_fsm
  import path_ctrl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   vbus_ok_i,
  input  logic   det_done_i,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (!vbus_ok_i) phase_d = PH_OFF;
    else begin
      unique case (phase_q)
        PH_OFF:    phase_d = PH_DETECT;
        PH_DETECT: if (det_done_i) phase_d = PH_READY;
        PH_READY:  phase_d = PH_READY;
        default:   phase_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_OFF;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R10
  det_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DETECT && vbus_ok_i && !det_done_i) |=> phase_q == PH_DETECT);

  // R1
  off_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vbus_ok_i |=> phase_q == PH_OFF);
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import path_ctrl_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vbus_ok_i,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mux_q_o,
  output logic [DW-1:0] cfg_q_o
);
  logic [DW-1:0] mux_q, cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mux_q <= MUX_RST;
      cfg_q <= CFG_RST;
    end else if (!vbus_ok_i) begin
      mux_q <= MUX_RST;
      cfg_q <= CFG_RST;
    end else if (we_i) begin
      if (sel_i == SEL_MUX) mux_q <= wdata_i;
      else                  cfg_q <= wdata_i;
    end
  end

  assign mux_q_o = mux_q;
  assign cfg_q_o = cfg_q;

  // R8
  uvlo_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vbus_ok_i |=> (mux_q == MUX_RST && cfg_q == CFG_RST));
endmodule

// File: rtl/en_gate.sv
module en_gate
  import path_ctrl_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_i,
  input  logic [DW-1:0] mux_q_i,
  input  logic [DW-1:0] cfg_q_i,
  output logic          mux_a_en_o,
  output logic          mux_b_en_o,
  output logic          ilim_o,
  output logic          full_path_o
);
  logic ready, bypass;

  assign ready  = (phase_i == PH_READY);
  assign bypass = cfg_q_i[OVP_BIT] & cfg_q_i[OVR_BIT];

  // mux A has priority when both are requested
  assign mux_a_en_o  = ready & mux_q_i[MUX_A_BIT];
  assign mux_b_en_o  = ready & mux_q_i[MUX_B_BIT] & ~mux_q_i[MUX_A_BIT];
  assign full_path_o = ready & bypass;
  assign ilim_o      = ~full_path_o;

  // R5
  mux_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mux_a_en_o && mux_b_en_o));

  // R2
  gate_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != PH_READY) |-> (!mux_a_en_o && !mux_b_en_o && !full_path_o));
endmodule

// File: rtl/path_sw_ctrl.sv
module path_sw_ctrl
  import path_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vbus_ok_i,
  input  logic             det_done_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic             mux_a_en_o,
  output logic             mux_b_en_o,
  output logic             ilim_o,
  output logic             full_path_o
);
  phase_e           phase;
  logic [REG_W-1:0] mux_q, cfg_q;

  pwr_phase_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vbus_ok_i  (vbus_ok_i),
    .det_done_i (det_done_i),
    .phase_o    (phase)
  );

  cfg_regs #(.DW(REG_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vbus_ok_i (vbus_ok_i),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .mux_q_o   (mux_q),
    .cfg_q_o   (cfg_q)
  );

  en_gate #(.DW(REG_W)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_i     (phase),
    .mux_q_i     (mux_q),
    .cfg_q_i     (cfg_q),
    .mux_a_en_o  (mux_a_en_o),
    .mux_b_en_o  (mux_b_en_o),
    .ilim_o      (ilim_o),
    .full_path_o (full_path_o)
  );
endmodule

// File: tb/path_sw_ctrl_bench.sv
module path_sw_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vbus_ok_i = 1'b0;
  logic       det_done_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic       reg_sel_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic       mux_a_en_o, mux_b_en_o, ilim_o, full_path_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  path_sw_ctrl u_path_sw_ctrl (.*);

  // packed {mux_a, mux_b, ilim, full}
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {mux_a_en_o, mux_b_en_o, ilim_o, full_path_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // drive on falling edge, result visible after next rising edge
  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    step();
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask

  task automatic set_vbus(input logic v);
    @(negedge clk_i); vbus_ok_i = v;
    step();
  endtask

  task automatic pulse_done();
    @(negedge clk_i); det_done_i = 1'b1;
    step();
    @(negedge clk_i); det_done_i = 1'b0;
  endtask

  localparam logic [3:0] IDLE = 4'b0010;

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    chk("R1 reset", IDLE);

    // R9: done strobe while VBUS absent
    pulse_done();
    step();
    chk("R9 done while off", IDLE);

    // R8: writes while VBUS low must not stick
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h05);
    chk("R8 write while off", IDLE);

    set_vbus(1'b1);
    chk("R2 detect entry", IDLE);
    repeat (5) step();
    chk("R10 detect held", IDLE);
    pulse_done();
    // defaults: mux A only, limit active
    chk("R3 R4 R8 defaults after detect", 4'b1010);

    // R9: done strobe in ready phase
    pulse_done();
    chk("R9 done while ready", 4'b1010);

    // R4 R5 R6 exhaustive register sweep
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 8; c++) begin
        logic ea, eb, ef;
        wr(1'b0, 8'(m));
        wr(1'b1, 8'(c));
        ea = m[0];
        eb = m[1] & ~m[0];
        ef = c[0] & c[2];
        chk("R4 R5 R6 sweep", {ea, eb, ~ef, ef});
      end
    end

    // R1: VBUS loss with bypass and mux B requested
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h05);
    chk("R6 bypass ready", 4'b0101);
    set_vbus(1'b0);
    chk("R1 vbus loss", IDLE);

    // R7: defaults restored after return
    set_vbus(1'b1);
    pulse_done();
    chk("R7 defaults restored", 4'b1010);

    // R2: writes during detection stay gated, apply after done
    set_vbus(1'b0);
    set_vbus(1'b1);
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h05);
    chk("R2 gated during detect", IDLE);
    repeat (3) step();
    chk("R10 still detecting", IDLE);
    pulse_done();
    chk("R2 R4 R6 applied after done", 4'b0101);

    // R5: both requested, A wins
    wr(1'b0, 8'h03);
    chk("R5 priority", 4'b1001);

    // R6: only one bypass bit
    wr(1'b1, 8'h04);
    chk("R6 single bit ovr", 4'b1010);
    wr(1'b1, 8'h01);
    chk("R6 single bit ovp", 4'b1010);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule